// File: doc/BRIEF.md
# Ping-Pong Pixel Hit Counter

This block is the digital counting cell of one pixel in a photon-counting imager. Pulses from the pixel's discriminator are synchronized to the system clock and edge-detected. Each pulse then adds one to whichever of two saturating hit counters is active. The other counter holds a frozen value for readout. A readout strobe swaps the two roles in a single clock edge. The counter that becomes active starts from zero, and the counter that becomes held keeps its final value. Counting therefore never pauses while the array reads a value out.

A registered nonzero flag follows the held counter and feeds the channel priority encoder that sparsifies readout. A small serial chain holds the per-pixel settings: a 12-bit configuration word and two mask bits. One mask bit silences a noisy pixel. The other forces one count for every count-clock period, as a test aid. The chain's output bit lets pixels be daisy-chained. All pins are plain control and status levels. The readout is strobe-driven, so there is no valid/ready handshake and no back-pressure to honour: the held value stays valid until the next strobe edge.

Top module: `pixel_pingpong_counter`

## Requirements
- R1: After reset, held_count is 0, held_nz is 0, cfg_word is 0, mask_off is 0 and mask_on is 0. Counter A (selector 0) is active first.
- R2: Each rising edge of disc_in (high and low for at least two clock periods each) adds exactly one to the active counter, on the third rising clock edge after disc_in rises.
- R3: On a clock edge where rd_strobe is high and was low at the previous edge, the roles swap. From then on, held_count shows the final value of the previously active counter, and the new active counter restarts at 0. Keeping rd_strobe high causes no further swaps.
- R4: A hit that falls on the swap edge is counted in the newly active counter, which then starts at 1. No hit is lost.
- R5: The active counter saturates at 31 and never wraps.
- R6: held_count does not change between swaps, whatever hits arrive.
- R7: While mask_off is 1, no hit of any kind changes the active counter. This holds even when mask_on is also 1.
- R8: While mask_on is 1 and mask_off is 0, every clock edge with count_tick high counts one hit. A discriminator hit and a tick on the same edge count as one.
- R9: held_nz is 1 exactly when held_count is nonzero, and it changes on the same edge.
- R10: On each clock edge with cfg_load_en high, the 14-bit chain {cfg_word[11:0], mask_on, mask_off} shifts left by one, and cfg_sdi enters at mask_off. After 14 shifts, the first bit shifted in sits in cfg_word[11]. With cfg_load_en low, the chain holds.
- R11: cfg_sdo always equals the chain's top bit, cfg_word[11].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disc_in | input | 1 | Discriminator output, asynchronous |
| count_tick | input | 1 | One-cycle marker of each count-clock period |
| rd_strobe | input | 1 | Readout strobe, synchronous; its rising edge swaps the counters |
| cfg_load_en | input | 1 | Shift enable for the settings chain |
| cfg_sdi | input | 1 | Serial data into the settings chain |
| cfg_sdo | output | 1 | Serial data out of the settings chain |
| cfg_word | output | 12 | Per-pixel configuration word |
| mask_off | output | 1 | Pixel silenced |
| mask_on | output | 1 | Forced count per tick |
| held_count | output | 5 | Value of the held counter |
| held_nz | output | 1 | Held counter is nonzero |

## Verification
A discriminator rise is due in the active counter three clock edges later: two synchronizer stages, then the counter register. The bench therefore lets each pulse task run four negative edges before it swaps, and it reads a count only through held_count after a swap. A strobe rise, a tick and a shift bit each take effect at the first rising edge that samples them. The bench drives all inputs on a falling edge and checks at the next falling edge. The coincident-hit case lines up the strobe with the edge on which the third-stage increment lands, so the hit and the swap meet exactly.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  localparam int unsigned PXC_CNT_W       = 5;
  localparam int unsigned PXC_CFG_W       = 12;
  localparam int unsigned PXC_SYNC_STAGES = 2;
endpackage

// File: rtl/pxc_edge_sync.sv
// Multi-stage synchronizer followed by a rising-edge detector.
module pxc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], d};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pxc_sat_counter.sv
// Saturating up-counter with a clear that may preload one.
module pxc_sat_counter #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               q <= '0;
    else if (clr)             q <= inc ? W'(1) : '0;
    else if (inc && q != TOP) q <= q + W'(1);
  end
endmodule

// File: rtl/pxc_cfg_chain.sv
// Serial settings chain: {cfg, mask_on, mask_off}, shifted left.
module pxc_cfg_chain #(
  parameter int unsigned CFG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             sdi,
  output logic             sdo,
  output logic [CFG_W-1:0] cfg_q,
  output logic             mask_on_q,
  output logic             mask_off_q
);
  localparam int unsigned CHAIN_W = CFG_W + 2;
  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chain <= '0;
    else if (load_en) chain <= {chain[CHAIN_W-2:0], sdi};
  end

  assign cfg_q      = chain[CHAIN_W-1:2];
  assign mask_on_q  = chain[1];
  assign mask_off_q = chain[0];
  assign sdo        = chain[CHAIN_W-1];
endmodule

// File: rtl/pixel_pingpong_counter.sv
module pixel_pingpong_counter
  import pxc_pkg::*;
#(
  parameter int unsigned CNT_W       = PXC_CNT_W,
  parameter int unsigned CFG_W       = PXC_CFG_W,
  parameter int unsigned SYNC_STAGES = PXC_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disc_in,
  input  logic             count_tick,
  input  logic             rd_strobe,
  input  logic             cfg_load_en,
  input  logic             cfg_sdi,
  output logic             cfg_sdo,
  output logic [CFG_W-1:0] cfg_word,
  output logic             mask_off,
  output logic             mask_on,
  output logic [CNT_W-1:0] held_count,
  output logic             held_nz
);
  logic                  hit_edge;
  logic                  hit;
  logic                  strobe_q;
  logic                  swap;
  logic                  sel;
  logic [1:0][CNT_W-1:0] cnt;
  logic [CNT_W-1:0]      act_count;

  pxc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (disc_in),
    .rise (hit_edge)
  );

  pxc_cfg_chain #(.CFG_W(CFG_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (cfg_load_en),
    .sdi       (cfg_sdi),
    .sdo       (cfg_sdo),
    .cfg_q     (cfg_word),
    .mask_on_q (mask_on),
    .mask_off_q(mask_off)
  );

  assign hit  = (hit_edge | (mask_on & count_tick)) & ~mask_off;
  assign swap = rd_strobe & ~strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      sel      <= 1'b0;
      held_nz  <= 1'b0;
    end else begin
      strobe_q <= rd_strobe;
      if (swap) begin
        sel     <= ~sel;
        held_nz <= |act_count;
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic is_act;
    logic clr_g;
    logic inc_g;
    assign is_act = (sel == 1'(g));
    assign clr_g  = swap & ~is_act;
    assign inc_g  = hit & (swap ? ~is_act : is_act);
    pxc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr_g),
      .inc  (inc_g),
      .q    (cnt[g])
    );
  end

  assign act_count  = cnt[sel];
  assign held_count = cnt[~sel];
endmodule

// File: rtl/pxc_checker.sv
module pxc_checker #(
  parameter int unsigned CNT_W = 5,
  parameter int unsigned CFG_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             swap,
  input logic             mask_off,
  input logic             cfg_load_en,
  input logic [CFG_W-1:0] cfg_word,
  input logic [CNT_W-1:0] act_count,
  input logic [CNT_W-1:0] held_count,
  input logic             held_nz
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R6
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |=> $stable(held_count));

  // R3
  swap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> held_count == $past(act_count));

  // R9
  nz_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_nz == (held_count != '0));

  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_off && !swap) |=> act_count == $past(act_count));

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_count == TOP && !swap) |=> act_count == TOP);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load_en |=> $stable(cfg_word));
endmodule

bind pixel_pingpong_counter pxc_checker #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .swap       (swap),
  .mask_off   (mask_off),
  .cfg_load_en(cfg_load_en),
  .cfg_word   (cfg_word),
  .act_count  (act_count),
  .held_count (held_count),
  .held_nz    (held_nz)
);

// File: tb/tb_pixel_pingpong_counter.sv
`timescale 1ns/1ps
module tb_pixel_pingpong_counter;
  logic clk = 0, rst_n = 0;
  logic disc_in = 0, count_tick = 0, rd_strobe = 0, cfg_load_en = 0, cfg_sdi = 0;
  logic cfg_sdo, mask_off, mask_on, held_nz;
  logic [11:0] cfg_word;
  logic [4:0]  held_count;

  int tests = 0, fails = 0;
  int exp_act = 0;
  bit e_off = 0, e_on = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pixel_pingpong_counter dut (.*);

  function automatic int sat_add(int a, int n);
    return (a + n > 31) ? 31 : a + n;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse();
    @(negedge clk) disc_in = 1;
    @(negedge clk);
    @(negedge clk) disc_in = 0;
    @(negedge clk);
    @(negedge clk);
    if (!e_off) exp_act = sat_add(exp_act, 1);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) count_tick = 1;
      if (e_on && !e_off) exp_act = sat_add(exp_act, 1);
    end
    @(negedge clk) count_tick = 0;
  endtask

  task automatic swap_check(string req);
    @(negedge clk) rd_strobe = 1;
    @(negedge clk) rd_strobe = 0;
    check(req, held_count, exp_act);
    check("R9", held_nz, exp_act != 0);
    exp_act = 0;
  endtask

  task automatic load_cfg(logic [13:0] w);
    for (int i = 13; i >= 0; i--) begin
      @(negedge clk) cfg_load_en = 1; cfg_sdi = w[i];
    end
    @(negedge clk) cfg_load_en = 0;
    e_on = w[1]; e_off = w[0];
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [13:0] w;
    int held_prev;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 held", held_count, 0);
    check("R1 nz", held_nz, 0);
    check("R1 cfg", cfg_word, 0);
    check("R1 masks", {mask_on, mask_off}, 0);

    // R2 counting, R3 swap
    repeat (7) pulse();
    swap_check("R2");
    repeat (3) pulse();
    swap_check("R3");

    // R6 held stays while counting
    repeat (4) pulse();
    swap_check("R6 capture");
    held_prev = 4;
    repeat (5) pulse();
    check("R6", held_count, held_prev);

    // R4 hit on the swap edge
    swap_check("R6 after");
    repeat (2) pulse();
    @(negedge clk) disc_in = 1;
    @(negedge clk);
    @(negedge clk) disc_in = 0; rd_strobe = 1;
    @(negedge clk) rd_strobe = 0;
    check("R4 old", held_count, 2);
    exp_act = 1;
    repeat (3) @(negedge clk);
    swap_check("R4 new");

    // R3 strobe held high swaps once
    @(negedge clk) rd_strobe = 1;
    repeat (3) pulse();
    @(negedge clk) rd_strobe = 0;
    check("R3 held high", held_count, 0);
    swap_check("R3 single");

    // R5 saturation
    repeat (35) pulse();
    swap_check("R5");

    // R10 and R11 config shift
    w = 14'b1011_0010_1110_00;
    load_cfg(w);
    check("R10 cfg", cfg_word, w[13:2]);
    check("R10 masks", {mask_on, mask_off}, w[1:0]);
    check("R11 sdo", cfg_sdo, w[13]);
    repeat (3) @(negedge clk);
    check("R10 hold", cfg_word, w[13:2]);

    // R8 forced count, and coincidence counts once
    load_cfg(14'h0002);
    ticks(6);
    @(negedge clk) disc_in = 1;
    @(negedge clk);
    @(negedge clk) disc_in = 0; count_tick = 1;
    @(negedge clk) count_tick = 0;
    exp_act = sat_add(exp_act, 1);
    repeat (3) @(negedge clk);
    swap_check("R8");

    // R7 mask_off wins over mask_on
    load_cfg(14'h0003);
    repeat (3) pulse();
    ticks(4);
    swap_check("R7");

    // random rounds
    for (int r = 0; r < 16; r++) begin
      int mode = $urandom % 3;
      int n = $urandom % 40;
      load_cfg(mode == 1 ? 14'h0002 : (mode == 2 ? 14'h0001 : 14'h0000));
      if (mode == 1) ticks(n);
      else for (int k = 0; k < n; k++) pulse();
      repeat (2) @(negedge clk);
      swap_check(mode == 2 ? "R7 rand" : (mode == 1 ? "R8 rand" : "R2 rand"));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule